// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides which DMA requester owns the bus. Each DMA channel has two request slots, A and B. In split-address operation both slots are independent requesters. In full-address operation the channel is one requester at the position of its A slot, and its B slot is ignored. A request is held pending until it is served. A new owner is chosen only while the bus is released. The choice is a fixed priority: the lowest slot index wins.

A granted requester runs transfers. Each transfer is a read phase followed by a write phase. The external transfer engine steps each phase with a completion strobe. For a single transfer, the bus is released after every read/write pair. For a burst or block transfer, the owner keeps the bus until the engine signals the final pair. A one-cycle request-clear pulse marks the start of every new grant. Between two grants there is always one idle cycle, and that idle cycle is the arbitration point.

Top module: `dma_chan_arbiter`

## Requirements
- R1: With every channel in split mode, slot i belongs to channel i/2 (even slot is A, odd slot is B). Among pending slots, the lowest index is granted, so the order is 0A, 0B, 1A, 1B.
- R2: When `full_mode_i[c]` is 1, channel c requests only through slot 2c. Requests on slot 2c+1 are not recorded, and that slot is never granted.
- R3: A new grant is chosen only in the idle (released) state. A request that arrives during a transfer does not change the current grant.
- R4: A request that loses arbitration, or that arrives during a transfer, stays pending. It is granted at a later arbitration point.
- R5: After a grant, `rd_phase_o` is high until `done_i`, and then `wr_phase_o` is high until `done_i`. The two phases are never high together, and they are high exactly while a grant is held.
- R6: Burst type (field code 01) keeps the same grant across read/write pairs. The grant is released only when the write phase completes with `last_i` high.
- R7: Block type (field code 10) keeps the grant until the write phase that completes with `last_i` high (end of block). Pending requests are then arbitrated.
- R8: Single type (codes 00 and 11) releases the bus after every read/write pair, whatever `last_i` is. A higher-priority request can then take over.
- R9: `req_clr_o` pulses for one cycle, in the first read cycle of a new grant and equal to the grant. The pending request of that slot is cleared at the same time.
- R10: After a release, the grant is zero for at least one idle cycle before the next grant.
- R11: `grant_o` is one-hot or all zero.
- R12: The transfer type is captured when a grant is issued. Changes to `full_mode_i` or `xfer_type_i` during a grant take effect only at the next arbitration.
- R13: After reset the grant, the phase outputs and the request-clear pulse are zero, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2*NCH | Request pulse per slot (slot 2c = channel c A, 2c+1 = channel c B) |
| full_mode_i | input | NCH | Per channel: 1 = full-address (single requester), 0 = split A/B |
| xfer_type_i | input | 4*NCH | Two bits per slot at [2i+1:2i]: 00 single, 01 burst, 10 block, 11 single |
| done_i | input | 1 | Current read or write phase finished |
| last_i | input | 1 | With done_i in write phase: end of burst or block |
| grant_o | output | 2*NCH | One-hot bus grant |
| req_clr_o | output | 2*NCH | One-cycle clear of the granted slot's request |
| rd_phase_o | output | 1 | Read phase of current transfer |
| wr_phase_o | output | 1 | Write phase of current transfer |

## Verification
The bench builds the block with NCH = 2, which gives four slots. That is enough to drive both channels in split mode, both in full mode, and the mixed case where channel 0 is split and channel 1 is full. It uses directed sequences for three cases: simultaneous requests, requests that arrive during read or write phases of single, burst and block transfers, and mode or type changes made while a grant is held.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH = 2,
  localparam int NSLOT = 2 * NCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   req_i,
  input  logic [NCH-1:0]     full_mode_i,
  input  logic [2*NSLOT-1:0] xfer_type_i,
  input  logic               done_i,
  input  logic               last_i,
  output logic [NSLOT-1:0]   grant_o,
  output logic [NSLOT-1:0]   req_clr_o,
  output logic               rd_phase_o,
  output logic               wr_phase_o
);

  localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t              st;
  logic [NSLOT-1:0] pend, gnt, clr, vmask, cand, win;
  logic [1:0]       typ, sel_typ;
  logic             arb, rel;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      vmask[2*c]   = 1'b1;
      vmask[2*c+1] = ~full_mode_i[c];
    end
  end

  assign cand = (pend | req_i) & vmask;
  assign win  = cand & (~cand + ONE);
  assign arb  = (st == S_IDLE) && (|cand);

  always_comb begin
    sel_typ = 2'b00;
    for (int i = 0; i < NSLOT; i++)
      if (win[i]) sel_typ = xfer_type_i[2*i +: 2];
  end

  assign rel = (typ == 2'b00) || (typ == 2'b11) || last_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pend <= '0;
      gnt  <= '0;
      clr  <= '0;
      typ  <= 2'b00;
    end else begin
      pend <= (pend | (req_i & vmask)) & ~(arb ? win : '0);
      clr  <= '0;
      case (st)
        S_IDLE: if (arb) begin
          st  <= S_RD;
          gnt <= win;
          clr <= win;
          typ <= sel_typ;
        end
        S_RD: if (done_i) st <= S_WR;
        S_WR: if (done_i) begin
          if (rel) begin
            st  <= S_IDLE;
            gnt <= '0;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign grant_o    = gnt;
  assign req_clr_o  = clr;
  assign rd_phase_o = (st == S_RD);
  assign wr_phase_o = (st == S_WR);

  a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r5_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_phase_o && wr_phase_o) && ((rd_phase_o || wr_phase_o) == (|grant_o)));

  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_phase_o) |-> $past(rd_phase_o));

  a_r6_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o && |$past(grant_o)) |-> (grant_o == $past(grant_o)));

  a_r9_clr_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_clr_o) |-> (req_clr_o == grant_o) && rd_phase_o);

  a_r10_idle_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_clr_o) |-> ($past(grant_o) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_bchk
    a_r2_b_masked: assert property (@(posedge clk) disable iff (!rst_n)
      req_clr_o[2*c+1] |-> !$past(full_mode_i[c]));
  end

endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = '0;
  logic [1:0] full_mode_i = '0;
  logic [7:0] xfer_type_i = '0;
  logic       done_i = 1'b0;
  logic       last_i = 1'b0;
  logic [3:0] grant_o, req_clr_o;
  logic       rd_phase_o, wr_phase_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  dma_chan_arbiter #(.NCH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .full_mode_i(full_mode_i),
    .xfer_type_i(xfer_type_i), .done_i(done_i), .last_i(last_i),
    .grant_o(grant_o), .req_clr_o(req_clr_o),
    .rd_phase_o(rd_phase_o), .wr_phase_o(wr_phase_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(logic [3:0] m);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  // one read/write pair on the current grant; xreq pulses during the read phase
  task automatic serve(int slot, bit first, bit lst, bit rel, logic [3:0] xreq, string tag);
    chk({tag, " grant"}, 32'(grant_o), 32'(1 << slot));
    chk({tag, " R5 read phase"}, 32'(rd_phase_o), 32'd1);
    chk({tag, " R9 clear"}, 32'(req_clr_o), first ? 32'(1 << slot) : 32'd0);
    done_i = 1'b1; req_i = xreq;
    @(negedge clk);
    done_i = 1'b0; req_i = '0;
    chk({tag, " R5 write phase"}, 32'(wr_phase_o), 32'd1);
    chk({tag, " R3 grant held"}, 32'(grant_o), 32'(1 << slot));
    done_i = 1'b1; last_i = lst;
    @(negedge clk);
    done_i = 1'b0; last_i = 1'b0;
    if (rel) begin
      chk({tag, " R10 idle after release"}, 32'(grant_o), 32'd0);
      @(negedge clk);
    end else begin
      chk({tag, " R6 still locked"}, 32'(grant_o), 32'(1 << slot));
      chk({tag, " R6 next read"}, 32'(rd_phase_o), 32'd1);
    end
  endtask

  task automatic t_reset();
    chk("R13 grant in reset", 32'(grant_o), 32'd0);
    chk("R13 phases in reset", 32'({rd_phase_o, wr_phase_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 no pending after reset", 32'(grant_o), 32'd0);
    chk("R13 no clear after reset", 32'(req_clr_o), 32'd0);
  endtask

  task automatic t_split_order();
    full_mode_i = 2'b00; xfer_type_i = 8'h00;
    pulse_req(4'b1111);
    serve(0, 1, 1, 1, 4'b0000, "R1 slot0A");
    serve(1, 1, 1, 1, 4'b0000, "R1 R4 slot0B");
    serve(2, 1, 1, 1, 4'b0000, "R1 R4 slot1A");
    serve(3, 1, 1, 1, 4'b0000, "R1 R4 slot1B");
    chk("R1 nothing left", 32'(grant_o), 32'd0);
  endtask

  task automatic t_full_mode();
    full_mode_i = 2'b11;
    pulse_req(4'b1111);
    serve(0, 1, 1, 1, 4'b0000, "R2 ch0 full");
    serve(2, 1, 1, 1, 4'b0000, "R2 ch1 full");
    chk("R2 B slots ignored", 32'(grant_o), 32'd0);
    full_mode_i = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R2 B requests not recorded", 32'(grant_o), 32'd0);
    full_mode_i = 2'b10;
    pulse_req(4'b0111);
    serve(0, 1, 1, 1, 4'b0000, "R2 mixed 0A");
    serve(1, 1, 1, 1, 4'b0000, "R2 mixed 0B");
    serve(2, 1, 1, 1, 4'b0000, "R2 mixed ch1");
    chk("R2 mixed done", 32'(grant_o), 32'd0);
    full_mode_i = 2'b00;
  endtask

  task automatic t_mid_transfer();
    xfer_type_i = 8'h00;
    pulse_req(4'b0100);
    serve(2, 1, 0, 1, 4'b0001, "R3 R8 late higher req");
    serve(0, 1, 0, 1, 4'b0000, "R4 pending served");
    chk("R3 done", 32'(grant_o), 32'd0);
  endtask

  task automatic t_burst();
    xfer_type_i = 8'b01_00_00_00;
    pulse_req(4'b1000);
    serve(3, 1, 0, 0, 4'b0001, "R6 burst pair1");
    serve(3, 0, 0, 0, 4'b0000, "R6 burst pair2");
    serve(3, 0, 1, 1, 4'b0000, "R6 burst last");
    serve(0, 1, 1, 1, 4'b0000, "R6 R4 after burst");
    xfer_type_i = 8'h00;
  endtask

  task automatic t_block();
    xfer_type_i = 8'b00_00_10_00;
    pulse_req(4'b0010);
    serve(1, 1, 0, 0, 4'b0001, "R7 block pair1");
    serve(1, 0, 1, 1, 4'b0000, "R7 block end");
    serve(0, 1, 1, 1, 4'b0000, "R7 R4 after block");
    xfer_type_i = 8'h00;
  endtask

  task automatic t_single_takeover();
    xfer_type_i = 8'h00;
    pulse_req(4'b1000);
    serve(3, 1, 0, 1, 4'b1001, "R8 single no last");
    serve(0, 1, 1, 1, 4'b0000, "R8 higher takes over");
    serve(3, 1, 1, 1, 4'b0000, "R8 R4 re-request");
    chk("R8 done", 32'(grant_o), 32'd0);
  endtask

  task automatic t_mode_change();
    full_mode_i = 2'b00; xfer_type_i = 8'b00_00_00_01;
    pulse_req(4'b0001);
    full_mode_i = 2'b01; xfer_type_i = 8'h00;
    serve(0, 1, 0, 0, 4'b0000, "R12 type latched");
    serve(0, 0, 1, 1, 4'b0000, "R12 burst end");
    pulse_req(4'b0010);
    @(negedge clk);
    chk("R12 R2 new mode applies", 32'(grant_o), 32'd0);
    full_mode_i = 2'b00;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_split_order();
    t_full_mode();
    t_mid_transfer();
    t_burst();
    t_block();
    t_single_takeover();
    t_mode_change();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule